// File: doc/BRIEF.md
# TDM Time-Slot Channel Access Unit

This unit attaches one serial HDLC channel to a time-division-multiplexed highway. A frame-sync pulse restarts an internal bit-position counter. A window of 1 to 8 bits opens at a programmable bit position. Inside that window the unit passes framer transmit bits onto the line and samples line receive bits for the framer. It also raises a driver-enable output, so an external line driver drives the highway only for those bits. A separate collision readback input is compared with every transmitted bit. A mismatch is reported both as a one-clock event and as a sticky flag.

The data clock can run at the bit rate or at twice the bit rate. At twice the rate, each bit lasts two clocks and the receive line is sampled in the middle of the bit. In strobe mode the frame-sync input no longer marks frame starts. It becomes a direct window strobe: every clock in which it is high carries one slot bit. The unit is meant to run at highway bit rates up to 4 Mb/s, with a data clock of up to 8 MHz.

A small register port sets the slot position, the slot length and the mode. Framing, FIFOs and the processor bus are built around this unit and are not part of it.

Top module: `tdm_slot_port`

## Requirements
- R1: While reset is held, and after its release until the first frame sync, tx_drive_en, rx_bit_vld, coll_evt and coll_sticky are 0 and ser_tx is 1.
- R2: A clock edge with cfg_we high stores cfg_wdata into the selected setting. cfg_addr 0 is the slot start position (all POS_W bits). cfg_addr 1 is the slot length minus one (bits [2:0]). cfg_addr 2 holds the mode: bit 0 selects the double-rate clock and bit 1 selects strobe mode. A write to cfg_addr 3 changes nothing.
- R3: In frame mode, a clock edge that samples frame_sync high makes the following clock bit position 0. Each later position lasts one clock at single rate and two clocks at double rate.
- R4: In frame mode, tx_drive_en is high exactly while the bit position p satisfies start <= p < start+length. During those clocks ser_tx equals tx_bit_in. In every other clock ser_tx is 1.
- R5: tx_bit_take is high in the last clock of each window bit and low otherwise. That is every window clock at single rate, and the second clock of each bit at double rate.
- R6: A window bit is sampled at the end of its clock at single rate, and at the end of its first clock at double rate. rx_bit_vld pulses for the one clock after each sample, and rx_bit_out then shows the sampled ser_rx.
- R7: At each sample point inside the window where coll_rx differs from ser_tx, coll_evt pulses in the next clock and coll_sticky is set. coll_sticky stays set until a clock edge with coll_clr high and no new mismatch; a mismatch at that same edge wins. coll_rx is ignored outside the window.
- R8: The bit position saturates at its all-ones value, and that value never lies inside the window. A slot that would extend past position 2^POS_W-2 is cut short, and the window does not reopen until the next frame sync.
- R9: In strobe mode, the window is open in exactly the clocks where frame_sync is high. Each such clock is one bit that is sampled and taken, whatever the double-rate setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, 1x or 2x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select |
| cfg_wdata | input | POS_W (8) | Setting write value |
| frame_sync | input | 1 | Frame start pulse, or the window strobe in strobe mode |
| ser_rx | input | 1 | Highway receive data |
| coll_rx | input | 1 | Collision readback of the transmit line |
| tx_bit_in | input | 1 | Next transmit bit from the framer |
| coll_clr | input | 1 | Clears the sticky collision flag |
| ser_tx | output | 1 | Highway transmit data, 1 when idle |
| tx_drive_en | output | 1 | External driver enable, high inside the window |
| tx_bit_take | output | 1 | Framer transmit bit consumed |
| rx_bit_out | output | 1 | Sampled receive bit |
| rx_bit_vld | output | 1 | One-clock strobe for rx_bit_out |
| coll_evt | output | 1 | One-clock collision event |
| coll_sticky | output | 1 | Sticky collision flag |

## Verification
The window function is swept over several start positions, every length from 1 to 8, and both clock rates. This separates off-by-one errors at the opening and closing edges of the window from errors in how the double-rate phase splits each bit. Transmit and receive bits follow different arithmetic patterns of the bit position, so swapped or shifted sampling shows up as a data mismatch rather than only as a timing mismatch. Collisions are injected on the first slot bit of some frames, and the readback is toggled freely outside the window; together these show that only in-window mismatches count. Separate runs check the reserved write, counter saturation near the top of the position range, and strobe mode with an irregular strobe pattern and double rate selected.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  typedef enum logic [1:0] {
    REG_POS  = 2'd0,
    REG_LEN  = 2'd1,
    REG_MODE = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  // packed: strobe is bit 1, dbl is bit 0
  typedef struct packed {
    logic strobe;
    logic dbl;
  } mode_t;

endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
  import tdm_slot_pkg::*;
#(
  parameter int unsigned POS_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [POS_W-1:0] wdata,
  output logic [POS_W-1:0] start,
  output logic [LEN_W-1:0] len_m1,
  output mode_t            mode
);

  logic [POS_W-1:0] start_q, start_d;
  logic [LEN_W-1:0] len_q, len_d;
  mode_t            mode_q, mode_d;

  always_comb begin
    start_d = start_q;
    len_d   = len_q;
    mode_d  = mode_q;
    if (we) begin
      unique case (reg_sel_e'(addr))
        REG_POS:  start_d = wdata;
        REG_LEN:  len_d   = wdata[LEN_W-1:0];
        REG_MODE: mode_d  = mode_t'(wdata[1:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= '0;
      mode_q  <= '0;
    end else begin
      start_q <= start_d;
      len_q   <= len_d;
      mode_q  <= mode_d;
    end
  end

  assign start  = start_q;
  assign len_m1 = len_q;
  assign mode   = mode_q;

endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic             dbl,
  input  logic             strobe,
  output logic [POS_W-1:0] pos,
  output logic             tick,
  output logic             sample
);

  localparam logic [POS_W-1:0] POS_SAT = '1;

  logic [POS_W-1:0] pos_q, pos_d;
  logic             phase_q, phase_d;
  logic             advance;

  // a bit position ends when the second half (2x) or the only clock (1x) ends
  assign advance = !dbl || phase_q;

  always_comb begin
    pos_d   = pos_q;
    phase_d = phase_q;
    if (!strobe) begin
      if (frame_sync) begin
        pos_d   = '0;
        phase_d = 1'b0;
      end else begin
        phase_d = dbl ? !phase_q : 1'b0;
        if (advance && (pos_q != POS_SAT)) begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= POS_SAT;
      phase_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      phase_q <= phase_d;
    end
  end

  assign pos    = pos_q;
  assign tick   = strobe || advance;
  assign sample = strobe || !dbl || !phase_q;

endmodule

// File: rtl/tdm_slot_window.sv
module tdm_slot_window #(
  parameter int unsigned POS_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] start,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             strobe,
  input  logic             frame_sync,
  output logic             in_slot
);

  localparam int unsigned     EXT_W   = POS_W + 1;
  localparam logic [POS_W-1:0] POS_SAT = '1;

  logic [EXT_W-1:0] lo_w;
  logic [EXT_W-1:0] hi_w;
  logic [EXT_W-1:0] pos_w;
  logic             framed;

  assign lo_w   = EXT_W'(start);
  assign hi_w   = EXT_W'(start) + EXT_W'(len_m1) + EXT_W'(1);
  assign pos_w  = EXT_W'(pos);
  assign framed = (pos != POS_SAT) && (pos_w >= lo_w) && (pos_w < hi_w);

  assign in_slot = strobe ? frame_sync : framed;

endmodule

// File: rtl/tdm_lane.sv
module tdm_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic in_slot,
  input  logic tick,
  input  logic sample,
  input  logic tx_bit_in,
  input  logic ser_rx,
  input  logic coll_rx,
  input  logic coll_clr,
  output logic ser_tx,
  output logic tx_drive_en,
  output logic tx_bit_take,
  output logic rx_bit_out,
  output logic rx_bit_vld,
  output logic coll_evt,
  output logic coll_sticky
);

  logic capture;
  logic mismatch;
  logic rxb_q, rxb_d;
  logic rxv_q, rxv_d;
  logic cev_q, cev_d;
  logic flg_q, flg_d;

  assign ser_tx      = in_slot ? tx_bit_in : 1'b1;
  assign tx_drive_en = in_slot;
  assign tx_bit_take = in_slot && tick;
  assign capture     = in_slot && sample;
  assign mismatch    = capture && (coll_rx != ser_tx);

  always_comb begin
    rxb_d = rxb_q;
    if (capture) begin
      rxb_d = ser_rx;
    end
    rxv_d = capture;
    cev_d = mismatch;
    flg_d = mismatch || (flg_q && !coll_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q <= 1'b0;
      rxv_q <= 1'b0;
      cev_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      rxb_q <= rxb_d;
      rxv_q <= rxv_d;
      cev_q <= cev_d;
      flg_q <= flg_d;
    end
  end

  assign rx_bit_out  = rxb_q;
  assign rx_bit_vld  = rxv_q;
  assign coll_evt    = cev_q;
  assign coll_sticky = flg_q;

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_slot_pkg::*;
#(
  parameter int unsigned POS_W = 8,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [POS_W-1:0] cfg_wdata,
  input  logic             frame_sync,
  input  logic             ser_rx,
  input  logic             coll_rx,
  input  logic             tx_bit_in,
  input  logic             coll_clr,
  output logic             ser_tx,
  output logic             tx_drive_en,
  output logic             tx_bit_take,
  output logic             rx_bit_out,
  output logic             rx_bit_vld,
  output logic             coll_evt,
  output logic             coll_sticky
);

  logic             rst_meta_q;
  logic             rst_core_n;
  logic [POS_W-1:0] start;
  logic [LEN_W-1:0] len_m1;
  mode_t            mode;
  logic [POS_W-1:0] pos;
  logic             tick;
  logic             sample;
  logic             in_slot;

  // asynchronous assertion, release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  tdm_cfg_regs #(.POS_W(POS_W), .LEN_W(LEN_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .start  (start),
    .len_m1 (len_m1),
    .mode   (mode)
  );

  tdm_bit_timer #(.POS_W(POS_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .frame_sync (frame_sync),
    .dbl        (mode.dbl),
    .strobe     (mode.strobe),
    .pos        (pos),
    .tick       (tick),
    .sample     (sample)
  );

  tdm_slot_window #(.POS_W(POS_W), .LEN_W(LEN_W)) u_window (
    .pos        (pos),
    .start      (start),
    .len_m1     (len_m1),
    .strobe     (mode.strobe),
    .frame_sync (frame_sync),
    .in_slot    (in_slot)
  );

  tdm_lane u_lane (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .in_slot     (in_slot),
    .tick        (tick),
    .sample      (sample),
    .tx_bit_in   (tx_bit_in),
    .ser_rx      (ser_rx),
    .coll_rx     (coll_rx),
    .coll_clr    (coll_clr),
    .ser_tx      (ser_tx),
    .tx_drive_en (tx_drive_en),
    .tx_bit_take (tx_bit_take),
    .rx_bit_out  (rx_bit_out),
    .rx_bit_vld  (rx_bit_vld),
    .coll_evt    (coll_evt),
    .coll_sticky (coll_sticky)
  );

endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic coll_clr,
  input logic ser_tx,
  input logic tx_drive_en,
  input logic tx_bit_take,
  input logic rx_bit_vld,
  input logic coll_evt,
  input logic coll_sticky
);

  // R4: line idles high whenever the driver is off
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_drive_en |-> ser_tx);

  // R5: a bit is only taken inside the window
  p_take_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_take |-> tx_drive_en);

  // R6: receive strobe follows a window clock
  p_rx_after_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_vld |-> $past(tx_drive_en));

  // R7: collision event follows a window clock
  p_evt_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |-> $past(tx_drive_en));

  // R7: event and flag appear together
  p_evt_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |-> coll_sticky);

  // R7: flag holds without a clear
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_sticky && !coll_clr) |=> coll_sticky);

endmodule

bind tdm_slot_port tdm_slot_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .coll_clr    (coll_clr),
  .ser_tx      (ser_tx),
  .tx_drive_en (tx_drive_en),
  .tx_bit_take (tx_bit_take),
  .rx_bit_vld  (rx_bit_vld),
  .coll_evt    (coll_evt),
  .coll_sticky (coll_sticky)
);

// File: tb/tdm_slot_port_bench.sv
module tdm_slot_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SWEEP_CYC  = 44;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       frame_sync;
  logic       ser_rx;
  logic       coll_rx;
  logic       tx_bit_in;
  logic       coll_clr;
  logic       ser_tx;
  logic       tx_drive_en;
  logic       tx_bit_take;
  logic       rx_bit_out;
  logic       rx_bit_vld;
  logic       coll_evt;
  logic       coll_sticky;

  int  n_cmp;
  int  n_bad;
  bit  finished;
  bit  m_rxv, m_rxb, m_cev, m_flag;

  tdm_slot_port u_tdm_slot_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .frame_sync  (frame_sync),
    .ser_rx      (ser_rx),
    .coll_rx     (coll_rx),
    .tx_bit_in   (tx_bit_in),
    .coll_clr    (coll_clr),
    .ser_tx      (ser_tx),
    .tx_drive_en (tx_drive_en),
    .tx_bit_take (tx_bit_take),
    .rx_bit_out  (rx_bit_out),
    .rx_bit_vld  (rx_bit_vld),
    .coll_evt    (coll_evt),
    .coll_sticky (coll_sticky)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
    end
  endtask

  // called just after a falling edge with this clock's inputs applied
  task automatic step(input string tag, input bit win, input bit tk, input bit smp);
    logic etx;
    #1;
    etx = win ? tx_bit_in : 1'b1;
    chk({tag, " R4 tx_drive_en"}, tx_drive_en, win);
    chk({tag, " R4 ser_tx"}, ser_tx, etx);
    chk({tag, " R5 tx_bit_take"}, tx_bit_take, win && tk);
    chk({tag, " R6 rx_bit_vld"}, rx_bit_vld, m_rxv);
    if (m_rxv) chk({tag, " R6 rx_bit_out"}, rx_bit_out, m_rxb);
    chk({tag, " R7 coll_evt"}, coll_evt, m_cev);
    chk({tag, " R7 coll_sticky"}, coll_sticky, m_flag);
    m_rxv  = win && smp;
    if (win && smp) m_rxb = ser_rx;
    m_cev  = win && smp && (coll_rx != etx);
    m_flag = m_cev || (m_flag && !coll_clr);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    frame_sync = 1'b0; tx_bit_in = 1'b1; ser_rx = 1'b0;
    coll_rx = 1'b1; coll_clr = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(input string tag, input int st, input int ln, input bit dbl,
                           input int ncyc, input bit inj, input bit clr0, input bit rsvd);
    idle_inputs();
    wr(0, st); wr(1, ln - 1); wr(2, {1'b0, dbl});
    if (rsvd) wr(3, 0);   // R2: reserved write must leave start alone
    frame_sync = 1'b1;
    step(tag, 1'b0, 1'b0, 1'b0);
    frame_sync = 1'b0;
    for (int j = 0; j < ncyc; j++) begin
      int n;
      bit win;
      logic etx;
      n = dbl ? j / 2 : j;
      if (n > 255) n = 255;
      win = (n != 255) && (n >= st) && (n < st + ln);
      tx_bit_in = 1'(((n * 5 + st + ln) >> 1) & 1);
      ser_rx    = 1'((((n * 7 + ln) >> 2) ^ n) & 1);
      etx       = win ? tx_bit_in : 1'b1;
      coll_rx   = win ? (etx ^ 1'(inj && n == st)) : 1'(n & 1);
      coll_clr  = clr0 && (j == 0);
      step(tag, win, dbl ? (j % 2 == 1) : 1'b1, dbl ? (j % 2 == 0) : 1'b1);
    end
  endtask

  initial begin
    automatic logic [23:0] spat = 24'b0110_1110_0011_0101_1110_0100;
    n_cmp = 0; n_bad = 0; finished = 1'b0;
    m_rxv = 0; m_rxb = 0; m_cev = 0; m_flag = 0;
    idle_inputs(); cfg_addr = 2'd0; cfg_wdata = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk("R1 reset tx_drive_en", tx_drive_en, 1'b0);
    chk("R1 reset ser_tx", ser_tx, 1'b1);
    chk("R1 reset rx_bit_vld", rx_bit_vld, 1'b0);
    chk("R1 reset coll_evt", coll_evt, 1'b0);
    chk("R1 reset coll_sticky", coll_sticky, 1'b0);
    rst_n = 1'b1;
    // R1: no window before the first frame sync, even with default slot at 0
    for (int k = 0; k < 6; k++) step("R1", 1'b0, 1'b0, 1'b0);

    // R3: sweep of position, length and rate
    foreach (spat[i]) begin end
    for (int d = 0; d < 2; d++) begin
      for (int si = 0; si < 5; si++) begin
        for (int ln = 1; ln <= 8; ln++) begin
          int st;
          st = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 3 : (si == 3) ? 7 : 12;
          run_frame("R3", st, ln, 1'(d), SWEEP_CYC, ((st + ln) % 3) == 0, ln == 4, 1'b0);
        end
      end
    end

    // R2: reserved address write ignored
    run_frame("R2", 5, 3, 1'b0, SWEEP_CYC, 1'b1, 1'b0, 1'b1);
    // R7: clear with no new mismatch drops the flag
    run_frame("R7", 2, 2, 1'b0, SWEEP_CYC, 1'b0, 1'b1, 1'b0);

    // R8: slot running into the saturated position
    run_frame("R8", 252, 8, 1'b0, 300, 1'b1, 1'b1, 1'b0);

    // R9: strobe mode with double rate set, which must be ignored
    idle_inputs();
    wr(2, 3);
    for (int j = 0; j < 24; j++) begin
      logic etx;
      frame_sync = spat[j];
      tx_bit_in  = 1'((j * 3 >> 1) & 1);
      ser_rx     = 1'((j >> 1) & 1);
      etx        = frame_sync ? tx_bit_in : 1'b1;
      coll_rx    = frame_sync ? (etx ^ 1'(j == 5)) : 1'(j & 1);
      coll_clr   = (j == 20);
      step("R9", frame_sync, 1'b1, 1'b1);
    end
    idle_inputs();
    step("R9", 1'b0, 1'b1, 1'b1);
    step("R9", 1'b0, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule